// File: doc/BRIEF.md
# Host Memory Window Decoder with Interrupt Steering

This block is the bus-side slave of an embedded 8-bit controller subsystem that sits on an ISA or PC/104 memory bus. It watches the 20-bit host address and the memory read and write strobes. It claims a 16 KB window when the upper address bits equal a set of strapped base-page pins and the chip-enable input is high. Inside the window the host reaches three things: a 4 KB mailbox RAM that the embedded core shares, a small page of control registers, and the core's 8 KB code RAM.

The core is kept in reset by a software hold bit or by the bus reset line. While it is held, the host downloads code into the code RAM. Clearing the hold bit lets the core run. One register picks which of eleven fixed host interrupt lines carries the core's interrupt request, and whether any line is driven at all.

The data bus is driven only during a decoded read. Both RAMs are plain arrays with asynchronous read ports.

Top module: `isa_window_dec`

## Requirements
- R1: The block responds only when `chip_en` is high and `sa[19:14]` equals `base_page`. Otherwise host writes change nothing and `sd_oe` stays low.
- R2: `sd_oe` is high only while the access is decoded (R1), `memr` is high and `memw` is low. In that case `sd_out` carries the read data in the same cycle.
- R3: Window offsets 0x0000–0x0FFF select the mailbox RAM. A host write lands on the next clock edge. A host read returns the stored byte.
- R4: The core reaches the mailbox through its own port. `core_mb_rdata` shows the byte at `core_mb_addr`, and `core_mb_we` writes `core_mb_wdata` on the clock edge. If the host and the core write the same byte in one cycle, the host's value is kept.
- R5: Even offsets in 0x1000–0x1FFF reach the control register, whose bit 0 is the core hold bit. A read returns `{7'b0, hold}`. `rst` sets the hold bit to 1.
- R6: `core_reset` equals the hold bit OR `bus_reset`. `bus_reset` also sets the hold bit to 1, taking priority over a host write in the same cycle.
- R7: Window offsets 0x2000–0x3FFF select the code RAM. A host write takes effect only while `core_reset` is high and is dropped otherwise. Host reads work at any time.
- R8: `code_rdata` shows the code RAM byte at `code_addr`.
- R9: Odd offsets in 0x1000–0x1FFF reach the interrupt select register. Bits 3:0 hold the interrupt number, bit 7 is the enable, and bits 6:4 always read back as 0. `rst` clears the register.
- R10: `irq_lines` bits 0 to 10 stand for host interrupts 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 in that order. A bit is high only when the enable is set, the number matches that line, and `core_irq` is high. Any other number drives no line, and at most one line is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_reset | input | 1 | Host bus reset line, active high |
| chip_en | input | 1 | Chip enable, active high |
| base_page | input | 6 | Strapped window base, compared with sa[19:14] |
| sa | input | 20 | Host memory address |
| memr | input | 1 | Host memory read strobe, active high |
| memw | input | 1 | Host memory write strobe, active high |
| sd_in | input | 8 | Host write data |
| sd_out | output | 8 | Host read data, zero when not enabled |
| sd_oe | output | 1 | Data bus output enable |
| core_irq | input | 1 | Interrupt request from the core |
| irq_lines | output | 11 | Host interrupt outputs, see R10 |
| core_reset | output | 1 | Reset to the embedded core |
| core_mb_addr | input | 12 | Core mailbox address |
| core_mb_wdata | input | 8 | Core mailbox write data |
| core_mb_we | input | 1 | Core mailbox write enable |
| core_mb_rdata | output | 8 | Core mailbox read data |
| code_addr | input | 13 | Core instruction fetch address |
| code_rdata | output | 8 | Code RAM byte at code_addr |

## Verification
The assertions assume that `memr` and `memw` are never high together. They also assume that `bus_reset` and `rst` are driven synchronously to `clk`. The bench keeps within these limits by driving every input at the falling edge and raising only one strobe per task call. Each strobe is held for exactly one rising edge, so a host write happens once. Reads are sampled shortly after the falling edge, while the strobe and the address are steady.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 8;
    localparam int WIN_W   = 14;
    localparam int BASE_W  = ADDR_W - WIN_W;
    localparam int MBOX_AW = 12;
    localparam int CODE_AW = 13;
    localparam int N_IRQ   = 11;

    typedef enum logic [1:0] {
        RGN_MBOX = 2'd0,
        RGN_REGS = 2'd1,
        RGN_CODE = 2'd2
    } region_e;

    typedef struct packed {
        logic    hit;
        logic    rd;
        logic    wr;
        region_e region;
    } dec_t;

    typedef struct packed {
        logic       en;
        logic [2:0] pad;
        logic [3:0] num;
    } irq_sel_t;

    // host interrupt number carried by output line idx
    function automatic logic [3:0] irq_num_of_line(input int idx);
        case (idx)
            0:       return 4'd3;
            1:       return 4'd4;
            2:       return 4'd5;
            3:       return 4'd6;
            4:       return 4'd7;
            5:       return 4'd9;
            6:       return 4'd10;
            7:       return 4'd11;
            8:       return 4'd12;
            9:       return 4'd14;
            default: return 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
    import isa_win_pkg::*;
(
    input  logic [ADDR_W-1:WIN_W-2] sa_hi,
    input  logic [BASE_W-1:0]       base_page,
    input  logic                    chip_en,
    input  logic                    memr,
    input  logic                    memw,
    output dec_t                    dec
);
    logic [1:0] quarter;

    always_comb begin
        quarter    = sa_hi[WIN_W-1:WIN_W-2];
        dec.hit    = chip_en && (sa_hi[ADDR_W-1:WIN_W] == base_page);
        dec.rd     = dec.hit && memr && !memw;
        dec.wr     = dec.hit && memw && !memr;
        unique case (quarter)
            2'b00:   dec.region = RGN_MBOX;
            2'b01:   dec.region = RGN_REGS;
            default: dec.region = RGN_CODE;
        endcase
    end
endmodule

// File: rtl/isa_ctrl_regs.sv
module isa_ctrl_regs
    import isa_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_reset,
    input  logic     wr_ctrl,
    input  logic     wr_irq,
    input  logic     hold_wdata,
    input  irq_sel_t irq_wdata,
    output logic     hold,
    output irq_sel_t irq_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= 1'b1;
            irq_sel <= '0;
        end else begin
            if (bus_reset)
                hold <= 1'b1;
            else if (wr_ctrl)
                hold <= hold_wdata;
            if (wr_irq) begin
                irq_sel.en  <= irq_wdata.en;
                irq_sel.pad <= 3'b000;
                irq_sel.num <= irq_wdata.num;
            end
        end
    end
endmodule

// File: rtl/isa_irq_steer.sv
module isa_irq_steer
    import isa_win_pkg::*;
(
    input  irq_sel_t         irq_sel,
    input  logic             core_irq,
    output logic [N_IRQ-1:0] irq_lines
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        localparam logic [3:0] LineNum = irq_num_of_line(i);
        assign irq_lines[i] = irq_sel.en && core_irq && (irq_sel.num == LineNum);
    end
endmodule

// File: rtl/isa_window_dec.sv
module isa_window_dec
    import isa_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset,
    input  logic               chip_en,
    input  logic [BASE_W-1:0]  base_page,
    input  logic [ADDR_W-1:0]  sa,
    input  logic               memr,
    input  logic               memw,
    input  logic [DATA_W-1:0]  sd_in,
    output logic [DATA_W-1:0]  sd_out,
    output logic               sd_oe,
    input  logic               core_irq,
    output logic [N_IRQ-1:0]   irq_lines,
    output logic               core_reset,
    input  logic [MBOX_AW-1:0] core_mb_addr,
    input  logic [DATA_W-1:0]  core_mb_wdata,
    input  logic               core_mb_we,
    output logic [DATA_W-1:0]  core_mb_rdata,
    input  logic [CODE_AW-1:0] code_addr,
    output logic [DATA_W-1:0]  code_rdata
);
    localparam int MBOX_DEPTH = 1 << MBOX_AW;
    localparam int CODE_DEPTH = 1 << CODE_AW;

    dec_t                dec;
    logic                hold;
    irq_sel_t            irq_sel;
    irq_sel_t            irq_wdata;
    logic                wr_ctrl;
    logic                wr_irq;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   mbox_mem [MBOX_DEPTH];
    logic [DATA_W-1:0]   code_mem [CODE_DEPTH];

    isa_addr_decode u_dec (
        .sa_hi     (sa[ADDR_W-1:WIN_W-2]),
        .base_page (base_page),
        .chip_en   (chip_en),
        .memr      (memr),
        .memw      (memw),
        .dec       (dec)
    );

    assign wr_ctrl   = dec.wr && (dec.region == RGN_REGS) && !sa[0];
    assign wr_irq    = dec.wr && (dec.region == RGN_REGS) &&  sa[0];
    assign irq_wdata = irq_sel_t'(sd_in);

    isa_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .wr_ctrl    (wr_ctrl),
        .wr_irq     (wr_irq),
        .hold_wdata (sd_in[0]),
        .irq_wdata  (irq_wdata),
        .hold       (hold),
        .irq_sel    (irq_sel)
    );

    isa_irq_steer u_irq (
        .irq_sel   (irq_sel),
        .core_irq  (core_irq),
        .irq_lines (irq_lines)
    );

    assign core_reset = hold || bus_reset;

    // mailbox: core write first, host write last so the host wins a collision
    always_ff @(posedge clk) begin
        if (core_mb_we)
            mbox_mem[core_mb_addr] <= core_mb_wdata;
        if (dec.wr && (dec.region == RGN_MBOX))
            mbox_mem[sa[MBOX_AW-1:0]] <= sd_in;
    end

    always_ff @(posedge clk) begin
        if (dec.wr && (dec.region == RGN_CODE) && core_reset)
            code_mem[sa[CODE_AW-1:0]] <= sd_in;
    end

    assign core_mb_rdata = mbox_mem[core_mb_addr];
    assign code_rdata    = code_mem[code_addr];

    always_comb begin
        unique case (dec.region)
            RGN_MBOX: rd_mux = mbox_mem[sa[MBOX_AW-1:0]];
            RGN_REGS: rd_mux = sa[0] ? DATA_W'(irq_sel) : {{(DATA_W-1){1'b0}}, hold};
            default:  rd_mux = code_mem[sa[CODE_AW-1:0]];
        endcase
    end

    assign sd_oe  = dec.rd;
    assign sd_out = dec.rd ? rd_mux : '0;

endmodule

// File: rtl/isa_window_chk.sv
module isa_window_chk
    import isa_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_reset,
    input logic              chip_en,
    input logic [BASE_W-1:0] base_page,
    input logic [ADDR_W-1:0] sa,
    input logic              memr,
    input logic              memw,
    input logic              sd_oe,
    input logic              core_irq,
    input logic [N_IRQ-1:0]  irq_lines,
    input logic              core_reset
);
    // R1
    no_select_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!chip_en || sa[ADDR_W-1:WIN_W] != base_page) |-> !sd_oe);

    // R2
    oe_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> (memr && !memw));

    // R5
    hold_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> core_reset);

    // R6
    bus_reset_drives_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |-> core_reset);

    // R6
    hold_after_bus_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_reset) |-> core_reset);

    // R10
    irq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));

    // R10
    irq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |-> core_irq);
endmodule

bind isa_window_dec isa_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_reset  (bus_reset),
    .chip_en    (chip_en),
    .base_page  (base_page),
    .sa         (sa),
    .memr       (memr),
    .memw       (memw),
    .sd_oe      (sd_oe),
    .core_irq   (core_irq),
    .irq_lines  (irq_lines),
    .core_reset (core_reset)
);

// File: tb/isa_window_dec_tb.sv
module isa_window_dec_tb;
    import isa_win_pkg::*;

    localparam logic [BASE_W-1:0] BASE  = 6'h2A;
    localparam logic [BASE_W-1:0] OTHER = 6'h15;
    localparam int NV = 12;
    // {write, window offset, data (written, or expected on read)}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 14'h0000, 8'h5A},
        {1'b1, 14'h0FFF, 8'hC3},
        {1'b1, 14'h2000, 8'h11},
        {1'b1, 14'h3FFF, 8'hEE},
        {1'b0, 14'h0000, 8'h5A},
        {1'b0, 14'h0FFF, 8'hC3},
        {1'b0, 14'h2000, 8'h11},
        {1'b0, 14'h3FFF, 8'hEE},
        {1'b0, 14'h1000, 8'h01},
        {1'b1, 14'h1001, 8'h85},
        {1'b0, 14'h1001, 8'h85},
        {1'b0, 14'h1FFF, 8'h85}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_reset = 1'b0;
    logic               chip_en = 1'b1;
    logic [BASE_W-1:0]  base_page = BASE;
    logic [ADDR_W-1:0]  sa = '0;
    logic               memr = 1'b0;
    logic               memw = 1'b0;
    logic [7:0]         sd_in = '0;
    logic [7:0]         sd_out;
    logic               sd_oe;
    logic               core_irq = 1'b0;
    logic [N_IRQ-1:0]   irq_lines;
    logic               core_reset;
    logic [MBOX_AW-1:0] core_mb_addr = '0;
    logic [7:0]         core_mb_wdata = '0;
    logic               core_mb_we = 1'b0;
    logic [7:0]         core_mb_rdata;
    logic [CODE_AW-1:0] code_addr = '0;
    logic [7:0]         code_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;
    logic       oe;

    always #2 clk = ~clk;

    isa_window_dec u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [BASE_W-1:0] pg, input logic [13:0] off, input logic [7:0] d);
        @(negedge clk);
        sa = {pg, off}; sd_in = d; memw = 1'b1;
        @(negedge clk);
        memw = 1'b0;
    endtask

    task automatic host_rd(input logic [BASE_W-1:0] pg, input logic [13:0] off);
        @(negedge clk);
        sa = {pg, off}; memr = 1'b1;
        #1;
        rd = sd_out; oe = sd_oe;
        @(negedge clk);
        memr = 1'b0;
    endtask

    function automatic string tag_of(input logic [13:0] off);
        if (off[13]) return "R7";
        if (off[12]) return off[0] ? "R9" : "R5";
        return "R3";
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R5 core_reset after rst", core_reset, 1);
        check("R10 irq idle after rst", irq_lines, 0);
        check("R2 oe idle", sd_oe, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22]) begin
                host_wr(BASE, VEC[i][21:8], VEC[i][7:0]);
            end else begin
                host_rd(BASE, VEC[i][21:8]);
                check({tag_of(VEC[i][21:8]), " vector read"}, rd, VEC[i][7:0]);
                check("R2 oe on read", oe, 1);
            end
        end

        // R10: irq 5 enabled from the table -> line index 2
        core_irq = 1'b1;
        #1 check("R10 irq5 line", irq_lines, 11'h004);
        core_irq = 1'b0;
        #1 check("R10 no request no line", irq_lines, 11'h000);
        core_irq = 1'b1;
        host_wr(BASE, 14'h1001, 8'h8F);
        check("R10 irq15 line", irq_lines, 11'h400);
        host_wr(BASE, 14'h1001, 8'h88);
        check("R10 invalid number", irq_lines, 11'h000);
        host_wr(BASE, 14'h1001, 8'h0F);
        check("R10 enable clear", irq_lines, 11'h000);
        host_wr(BASE, 14'h1001, 8'hF3);
        check("R10 irq3 line", irq_lines, 11'h001);
        host_rd(BASE, 14'h1001);
        check("R9 pad reads zero", rd, 8'h83);
        core_irq = 1'b0;

        // R1: foreign page and chip_en low
        host_rd(OTHER, 14'h0000);
        check("R1 foreign page no oe", oe, 0);
        host_wr(OTHER, 14'h0000, 8'h77);
        chip_en = 1'b0;
        host_rd(BASE, 14'h0000);
        check("R1 chip_en low no oe", oe, 0);
        host_wr(BASE, 14'h0000, 8'h66);
        chip_en = 1'b1;
        host_rd(BASE, 14'h0000);
        check("R1 writes ignored when unselected", rd, 8'h5A);

        // R2: write strobe alone never enables the bus
        @(negedge clk);
        sa = {BASE, 14'h0000}; memw = 1'b1; sd_in = 8'h5A;
        #1 check("R2 no oe on write", sd_oe, 0);
        @(negedge clk);
        memw = 1'b0;

        // R8: core fetch sees downloaded code
        code_addr = 13'h1FFF;
        #1 check("R8 code fetch", code_rdata, 8'hEE);

        // R5/R7: release core, then code write is dropped
        host_wr(BASE, 14'h1000, 8'h00);
        check("R5 release", core_reset, 0);
        host_rd(BASE, 14'h1000);
        check("R5 ctrl readback", rd, 8'h00);
        host_wr(BASE, 14'h2000, 8'h99);
        host_rd(BASE, 14'h2000);
        check("R7 code write ignored when running", rd, 8'h11);

        // R4: core port and collision
        @(negedge clk);
        core_mb_addr = 12'h123; core_mb_wdata = 8'hA5; core_mb_we = 1'b1;
        @(negedge clk);
        core_mb_we = 1'b0;
        host_rd(BASE, 14'h0123);
        check("R4 core write seen by host", rd, 8'hA5);
        host_wr(BASE, 14'h0456, 8'h3C);
        core_mb_addr = 12'h456;
        #1 check("R4 host write seen by core", core_mb_rdata, 8'h3C);
        @(negedge clk);
        sa = {BASE, 14'h0456}; sd_in = 8'hB1; memw = 1'b1;
        core_mb_wdata = 8'h4E; core_mb_we = 1'b1;
        @(negedge clk);
        memw = 1'b0; core_mb_we = 1'b0;
        check("R4 host wins collision", core_mb_rdata, 8'hB1);

        // R6: bus reset beats a release write, hold stays set afterwards
        @(negedge clk);
        bus_reset = 1'b1;
        #1 check("R6 bus reset drives core_reset", core_reset, 1);
        sa = {BASE, 14'h1000}; sd_in = 8'h00; memw = 1'b1;
        @(negedge clk);
        memw = 1'b0; bus_reset = 1'b0;
        #1 check("R6 hold set by bus reset", core_reset, 1);
        host_wr(BASE, 14'h2001, 8'h42);
        host_rd(BASE, 14'h2001);
        check("R7 code write in reset", rd, 8'h42);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule